// File: doc/BRIEF.md
# Sequential-Step Address Bus Codec

This block is a transmitter and receiver pair for an instruction-fetch address bus. Most fetch addresses follow the previous one by a fixed step, so the transmitter checks each new address against the last address it sent plus a step parameter. When the two match, it raises one extra wire, the step flag, and leaves every address line at its previous level. When they differ, it drives the address itself and keeps the step flag low.

The receiver keeps its own copy of the last address it delivered. On a transfer with the step flag high it adds the step to that copy. On a transfer with the flag low it takes the address lines as they are. A long run of sequential fetches therefore toggles no address line after the first transfer. Both halves act only on cycles where the valid strobe is high, and all address arithmetic wraps modulo 2^ADDR_W.

Top module: `step_addr_codec`

## Requirements
- R1: Each address presented with `tx_valid` high appears on `rx_addr` with `rx_valid` high exactly two clock cycles later. Addresses appear in the order they were presented.
- R2: On a valid transfer whose address is not the last sent address plus STRIDE, the next cycle shows `bus_step`=0 and `bus_addr` equal to that address.
- R3: On a valid transfer whose address equals the last sent address plus STRIDE, the next cycle shows `bus_step`=1 and `bus_addr` unchanged from its previous value.
- R4: The receiver, on a bus transfer with `bus_step`=1, outputs its previously delivered address plus STRIDE.
- R5: The first valid transfer after reset is always sent with `bus_step`=0, whatever its address.
- R6: The comparison and the receiver addition wrap modulo 2^ADDR_W. With ADDR_W=8 and STRIDE=4, address 0 after 252 is sent with `bus_step`=1.
- R7: Cycles with `tx_valid` low change no reference state. `bus_valid` and then `rx_valid` go low, `bus_addr` and `rx_addr` hold, and the next valid transfer is compared against the last one actually sent.
- R8: After reset, `bus_valid`, `bus_step`, `bus_addr`, `rx_valid` and `rx_addr` are all zero.
- R9: In an unbroken sequential run, the address lines make zero transitions after the run's first transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | New fetch address present |
| tx_addr | input | ADDR_W | Fetch address to transmit |
| bus_valid | output | 1 | Bus carries a transfer |
| bus_step | output | 1 | Step flag: receiver adds STRIDE |
| bus_addr | output | ADDR_W | Encoded address lines |
| rx_valid | output | 1 | Rebuilt address present |
| rx_addr | output | ADDR_W | Rebuilt address |

## Verification
On every cycle, assertions check several properties. They confirm that address lines hold whenever the step flag is raised and that the first transfer after reset is plain. They also check that the receiver adds the step or copies the lines as the flag says, that idle cycles leave the rebuilt address untouched, and that every presented address comes back two cycles later. Other properties are visible only in the bench's scenarios. These include correct choice of the step flag across every start address (including wraparound), chaining after idle gaps, and a zero transition count over a long run.

// File: rtl/step_codec_pkg.sv
package step_codec_pkg;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_STRIDE = 4;
endpackage

// File: rtl/step_encoder.sv
module step_encoder #(
    parameter int ADDR_W = step_codec_pkg::DEF_ADDR_W,
    parameter int STRIDE = step_codec_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_step,
    output logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    typedef struct packed {
        logic              primed;
        logic [ADDR_W-1:0] last;
        logic              valid;
        logic              step;
        logic [ADDR_W-1:0] lines;
    } enc_t;

    enc_t st_q, st_d;
    logic seq_hit;

    always_comb begin
        st_d       = st_q;
        seq_hit    = st_q.primed && (in_addr == st_q.last + STEP);
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.primed = 1'b1;
            st_d.last   = in_addr;
            st_d.step   = seq_hit;
            if (!seq_hit) begin
                st_d.lines = in_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_step  = st_q.step;
    assign out_addr  = st_q.lines;

    assert_lines_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_step) |-> (out_addr == $past(out_addr)));

    assert_first_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.primed && in_valid) |=> !out_step);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr)));
endmodule

// File: rtl/step_decoder.sv
module step_decoder #(
    parameter int ADDR_W = step_codec_pkg::DEF_ADDR_W,
    parameter int STRIDE = step_codec_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_step,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    dec_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.addr = in_step ? (st_q.addr + STEP) : in_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;

    assert_rebuild_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_step) |=> (out_valid && out_addr == $past(out_addr) + STEP));

    assert_copy_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_step) |=> (out_valid && out_addr == $past(in_addr)));

    assert_idle_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_addr)));
endmodule

// File: rtl/step_addr_codec.sv
module step_addr_codec #(
    parameter int ADDR_W = step_codec_pkg::DEF_ADDR_W,
    parameter int STRIDE = step_codec_pkg::DEF_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [ADDR_W-1:0] tx_addr,
    output logic              bus_valid,
    output logic              bus_step,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rx_valid,
    output logic [ADDR_W-1:0] rx_addr
);
    step_encoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_addr   (tx_addr),
        .out_valid (bus_valid),
        .out_step  (bus_step),
        .out_addr  (bus_addr)
    );

    step_decoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (bus_valid),
        .in_step   (bus_step),
        .in_addr   (bus_addr),
        .out_valid (rx_valid),
        .out_addr  (rx_addr)
    );

    assert_round_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> ##1 (rx_valid && rx_addr == $past(tx_addr, 2)));
endmodule

// File: tb/test_step_addr_codec.sv
module test_step_addr_codec;
    localparam int AW = 8;
    localparam int STRIDE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [AW-1:0] tx_addr = '0;
    logic          bus_valid, bus_step, rx_valid;
    logic [AW-1:0] bus_addr, rx_addr;

    always #2 clk = ~clk;

    step_addr_codec #(.ADDR_W(AW), .STRIDE(STRIDE)) i_step_addr_codec (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_addr(tx_addr),
        .bus_valid(bus_valid), .bus_step(bus_step), .bus_addr(bus_addr),
        .rx_valid(rx_valid), .rx_addr(rx_addr)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit            m_primed = 0;
    logic [AW-1:0] m_last = '0;
    logic [AW-1:0] m_lines = '0;
    bit            m_pend_v = 0;
    logic [AW-1:0] m_pend_a = '0;
    logic [AW-1:0] m_rx = '0;
    int            toggles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge, observe at following negedge
    task automatic xfer(input bit v, input logic [AW-1:0] a, input string tag);
        logic [AW-1:0] prev_lines;
        logic [AW-1:0] nxt;
        bit            exp_step;
        logic [AW-1:0] exp_lines;
        prev_lines = bus_addr;
        tx_valid = v;
        tx_addr  = a;
        nxt = m_last + AW'(STRIDE);
        exp_step  = m_primed && (a == nxt);
        exp_lines = (v && !exp_step) ? a : m_lines;
        @(posedge clk);
        @(negedge clk);
        toggles += $countones(bus_addr ^ prev_lines);
        chk(bus_valid == v, {tag, " bus_valid"}, int'(bus_valid), int'(v));
        chk(bus_addr == exp_lines, {tag, " bus_addr"}, int'(bus_addr), int'(exp_lines));
        if (v) chk(bus_step == exp_step, {tag, " bus_step"}, int'(bus_step), int'(exp_step));
        // rx shows the transfer presented one call earlier (R1)
        chk(rx_valid == m_pend_v, "R1 rx_valid", int'(rx_valid), int'(m_pend_v));
        if (m_pend_v) m_rx = m_pend_a;
        chk(rx_addr == m_rx, "R1 rx_addr", int'(rx_addr), int'(m_rx));
        if (v) begin
            m_primed = 1;
            m_last = a;
        end
        m_lines  = exp_lines;
        m_pend_v = v;
        m_pend_a = a;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_valid && !bus_step && !rx_valid, "R8 flags", int'({bus_valid, bus_step, rx_valid}), 0);
        chk(bus_addr == 0 && rx_addr == 0, "R8 addr", int'(bus_addr) + int'(rx_addr), 0);
        rst_n = 1'b1;

        // R5: first after reset is plain even if it equals 0+STRIDE
        xfer(1, AW'(STRIDE), "R5");

        // exhaustive: every start, then its successor (R2/R3/R6 wrap at top)
        for (int s = 0; s < (1 << AW); s++) begin
            xfer(1, AW'(s + 77), "R2");
            xfer(1, AW'(s), "R2");
            xfer(1, AW'(s + STRIDE), "R3 R6");
            xfer(0, '0, "R7");
        end

        // explicit wrap run 248,252,0,4 (R6)
        xfer(1, 8'd248, "R6");
        xfer(1, 8'd252, "R6");
        xfer(1, 8'd0, "R6");
        chk(bus_step == 1'b1, "R6 wrap step", int'(bus_step), 1);
        xfer(1, 8'd4, "R6");

        // gap then continuation (R7)
        xfer(1, 8'd40, "R7");
        xfer(0, 8'd99, "R7");
        xfer(0, 8'd44, "R7");
        xfer(1, 8'd44, "R7");
        chk(bus_step == 1'b1, "R7 chain after gap", int'(bus_step), 1);

        // long run: no address line toggles after first (R9)
        xfer(1, 8'd130, "R9");
        toggles = 0;
        for (int k = 1; k <= 32; k++) xfer(1, AW'(130 + k * STRIDE), "R9");
        chk(toggles == 0, "R9 toggles", toggles, 0);

        // random jumps mixed with sequential steps
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] r;
            r = AW'($urandom);
            if (r[0]) xfer(1, m_last + AW'(STRIDE), "R3");
            else if (r[1]) xfer(0, r, "R7");
            else xfer(1, r, "R2");
        end
        xfer(0, '0, "R1");
        xfer(0, '0, "R1");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule